// File: doc/BRIEF.md
# Packed Saturating Vector Add/Subtract Unit

This execution unit accepts one 32-bit instruction word together with two wide operand vectors and produces a lane-wise sum or difference one clock later. It recognises only the unpredicated integer add/subtract group. Within that group a 3-bit sub-opcode picks wrapping add, wrapping subtract, or an add or subtract that saturates in signed or unsigned arithmetic. A 2-bit size field splits the vector into 8, 16, 32 or 64-bit lanes, and every lane of the destination is written. The unit also returns the three register indices carried in the word, so the surrounding pipeline can write back the result and track its sources. Operands arrive already read from the register file.

The output stage is a three-state machine held in one register. `ST_IDLE` means no instruction was accepted on the last edge. `ST_RESULT` means a legal instruction was accepted and its result is on the outputs. `ST_FAULT` means an instruction outside the group was presented. The next state does not depend on the current one. The transition `accept` leads to `ST_RESULT` when `in_valid` is high and the word decodes as legal. The transition `reject` leads to `ST_FAULT` when `in_valid` is high and the word does not decode. The transition `drain` leads to `ST_IDLE` when `in_valid` is low. All three transitions are taken from any state.

Top module: `vsat_unit`

## Requirements
- R1: A word is in the group only when bits [31:24] are 8'b00000100, bit 21 is 1 and bits [15:13] are 3'b000. Any other word accepted with `in_valid` produces `out_illegal`.
- R2: Sub-opcodes 3'b010 and 3'b011 in bits [12:10] are outside the group and produce `out_illegal`, even when every other field matches.
- R3: For a legal word, `out_rd` carries bits [4:0], `out_rn` carries bits [9:5] and `out_rm` carries bits [20:16]. `src_a` is the operand read from register rn and `src_b` is the operand read from register rm.
- R4: The size field in bits [23:22] maps 2'b00, 2'b01, 2'b10 and 2'b11 to lanes of 8, 16, 32 and 64 bits. Every lane of `out_result` is computed.
- R5: Sub-opcode 3'b000 computes a+b modulo the lane width. No carry passes between lanes.
- R6: Sub-opcode 3'b001 computes a−b modulo the lane width. No borrow passes between lanes.
- R7: Sub-opcode 3'b100 is a signed add. On overflow the lane clamps to the most positive or the most negative lane value.
- R8: Sub-opcode 3'b101 is an unsigned add. On carry-out the lane clamps to all ones.
- R9: Sub-opcode 3'b110 is a signed subtract a−b. On overflow the lane clamps to the most positive or the most negative lane value.
- R10: Sub-opcode 3'b111 is an unsigned subtract a−b. On borrow the lane clamps to zero.
- R11: A word accepted on a rising edge with `in_valid` high is reported during the following cycle only. After an edge with `in_valid` low, both `out_valid` and `out_illegal` are low. Reset clears every output to zero.
- R12: On an illegal word, `out_illegal` is high, `out_valid` is low, and `out_result` and all three indices are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | VEC_W | First source vector (register rn) |
| src_b | input | VEC_W | Second source vector (register rm) |
| out_valid | output | 1 | Legal result present |
| out_illegal | output | 1 | Presented word was outside the group |
| out_rd | output | 5 | Destination register index |
| out_rn | output | 5 | First source register index |
| out_rm | output | 5 | Second source register index |
| out_result | output | VEC_W | Packed lane results |

## Verification
A table of hand-worked vectors covers each operation with a 64-bit operand pattern that is replicated across the vector. Some entries place all-ones lanes next to small addends, which separates true per-lane wrapping from carries that leak between lanes. Other entries push signed lanes across both limits in the same word, which separates a correct clamp direction from a one-sided clamp. Random operands at every sub-opcode and size are then compared with a reference model; some of these rounds use saturated-pattern operands to force the clamps at each width. Directed words with a wrong top byte, bit 21 clear, a non-zero bits [15:13] field, or sub-opcodes 010 and 011 separate the group match from the operation decode.

// File: rtl/vsat_pkg.sv
package vsat_pkg;

    localparam int CHUNK_W  = 64;
    localparam int N_SIZES  = 4;

    localparam logic [7:0] GROUP_TAG  = 8'b0000_0100;
    localparam int         TAG_HI     = 31;
    localparam int         TAG_LO     = 24;
    localparam int         SIZE_LO    = 22;
    localparam int         SEL_BIT    = 21;
    localparam int         RM_LO      = 16;
    localparam int         ZERO_LO    = 13;
    localparam int         SUB_LO     = 10;
    localparam int         RN_LO      = 5;
    localparam int         RD_LO      = 0;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_SQADD = 3'd3,
        OP_UQADD = 3'd4,
        OP_SQSUB = 3'd5,
        OP_UQSUB = 3'd6
    } vsat_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } vsat_state_e;

    typedef struct packed {
        logic [4:0] rd;
        logic [4:0] rn;
        logic [4:0] rm;
    } vsat_regs_t;

endpackage

// File: rtl/vsat_decode.sv
module vsat_decode
    import vsat_pkg::*;
(
    input  logic [31:0] instr,
    output logic        legal,
    output vsat_op_e    op,
    output logic [1:0]  esz,
    output vsat_regs_t  regs
);

    logic       group_hit;
    logic [2:0] sub;

    always_comb begin
        group_hit = (instr[TAG_HI:TAG_LO] == GROUP_TAG)
                  && instr[SEL_BIT]
                  && (instr[ZERO_LO+2:ZERO_LO] == 3'b000);
        sub       = instr[SUB_LO+2:SUB_LO];
        esz       = instr[SIZE_LO+1:SIZE_LO];
        regs.rd   = instr[RD_LO+4:RD_LO];
        regs.rn   = instr[RN_LO+4:RN_LO];
        regs.rm   = instr[RM_LO+4:RM_LO];

        op = OP_NONE;
        if (group_hit) begin
            unique case (sub)
                3'b000:  op = OP_ADD;
                3'b001:  op = OP_SUB;
                3'b100:  op = OP_SQADD;
                3'b101:  op = OP_UQADD;
                3'b110:  op = OP_SQSUB;
                3'b111:  op = OP_UQSUB;
                default: op = OP_NONE;
            endcase
        end
        legal = (op != OP_NONE);
    end

endmodule

// File: rtl/vsat_lane.sv
module vsat_lane
    import vsat_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  vsat_op_e          op,
    output logic [LANE_W-1:0] res
);

    localparam int MSB = LANE_W - 1;
    localparam logic [LANE_W-1:0] U_MAX = {LANE_W{1'b1}};
    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [LANE_W:0]   sum;
    logic [LANE_W:0]   dif;
    logic              ovf_add;
    logic              ovf_sub;
    logic [LANE_W-1:0] clamp_s;

    always_comb begin
        sum     = {1'b0, a} + {1'b0, b};
        dif     = {1'b0, a} - {1'b0, b};
        ovf_add = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        ovf_sub = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);
        clamp_s = a[MSB] ? S_MIN : S_MAX;

        unique case (op)
            OP_ADD:   res = sum[MSB:0];
            OP_SUB:   res = dif[MSB:0];
            OP_SQADD: res = ovf_add ? clamp_s : sum[MSB:0];
            OP_UQADD: res = sum[LANE_W] ? U_MAX : sum[MSB:0];
            OP_SQSUB: res = ovf_sub ? clamp_s : dif[MSB:0];
            OP_UQSUB: res = dif[LANE_W] ? '0 : dif[MSB:0];
            default:  res = '0;
        endcase

        // R8: an unsigned saturating sum never drops below either addend
        if (op == OP_UQADD) begin
            p_uqadd_floor_r8: assert (res >= a && res >= b);
        end
        // R10: an unsigned saturating difference never exceeds the minuend
        if (op == OP_UQSUB) begin
            p_uqsub_ceil_r10: assert (res <= a);
        end
        // R7: adding two values of one sign keeps that sign
        if (op == OP_SQADD && a[MSB] == b[MSB]) begin
            p_sqadd_sign_r7: assert (res[MSB] == a[MSB]);
        end
        // R9: subtracting a value of opposite sign keeps the minuend sign
        if (op == OP_SQSUB && a[MSB] != b[MSB]) begin
            p_sqsub_sign_r9: assert (res[MSB] == a[MSB]);
        end
    end

endmodule

// File: rtl/vsat_chunk.sv
module vsat_chunk
    import vsat_pkg::*;
(
    input  logic [CHUNK_W-1:0] a,
    input  logic [CHUNK_W-1:0] b,
    input  vsat_op_e           op,
    input  logic [1:0]         esz,
    output logic [CHUNK_W-1:0] res
);

    logic [N_SIZES-1:0][CHUNK_W-1:0] by_size;

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int W  = 8 << s;
        localparam int NL = CHUNK_W / W;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            vsat_lane #(.LANE_W(W)) u_lane (
                .a   (a[l*W +: W]),
                .b   (b[l*W +: W]),
                .op  (op),
                .res (by_size[s][l*W +: W])
            );
        end
    end

    always_comb begin
        res = by_size[esz];
    end

endmodule

// File: rtl/vsat_unit.sv
module vsat_unit
    import vsat_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [4:0]       out_rd,
    output logic [4:0]       out_rn,
    output logic [4:0]       out_rm,
    output logic [VEC_W-1:0] out_result
);

    localparam int NCHUNK = VEC_W / CHUNK_W;

    logic             dec_legal;
    vsat_op_e         dec_op;
    logic [1:0]       dec_esz;
    vsat_regs_t       dec_regs;
    logic [VEC_W-1:0] lane_res;

    vsat_state_e state_q;
    vsat_state_e state_nx;
    vsat_regs_t  regs_q;
    logic [VEC_W-1:0] result_q;

    vsat_decode u_decode (
        .instr (instr),
        .legal (dec_legal),
        .op    (dec_op),
        .esz   (dec_esz),
        .regs  (dec_regs)
    );

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        vsat_chunk u_chunk (
            .a   (src_a[c*CHUNK_W +: CHUNK_W]),
            .b   (src_b[c*CHUNK_W +: CHUNK_W]),
            .op  (dec_op),
            .esz (dec_esz),
            .res (lane_res[c*CHUNK_W +: CHUNK_W])
        );
    end

    // next state: accept, reject or drain, from any state
    always_comb begin
        if (!in_valid)      state_nx = ST_IDLE;
        else if (dec_legal) state_nx = ST_RESULT;
        else                state_nx = ST_FAULT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // data captured alongside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q   <= '0;
            result_q <= '0;
        end else if (in_valid) begin
            if (dec_legal) begin
                regs_q   <= dec_regs;
                result_q <= lane_res;
            end else begin
                regs_q   <= '0;
                result_q <= '0;
            end
        end
    end

    // outputs from state
    always_comb begin
        out_valid   = 1'b0;
        out_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: out_valid   = 1'b1;
            ST_FAULT:  out_illegal = 1'b1;
            default:   ;
        endcase
        out_rd     = regs_q.rd;
        out_rn     = regs_q.rn;
        out_rm     = regs_q.rm;
        out_result = result_q;
    end

    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_illegal}));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal));

    p_fault_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == '0 && out_rd == '0 && out_rn == '0 && out_rm == '0));

    p_group_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[TAG_HI:TAG_LO] != GROUP_TAG) |=> out_illegal);

    p_bad_subop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[SUB_LO+2:SUB_LO+1] == 2'b01) |=> out_illegal);

    p_dest_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_legal) |=> (out_valid && out_rd == $past(instr[4:0])));

endmodule

// File: tb/vsat_unit_test.sv
module vsat_unit_test;

    localparam int VW  = 128;
    localparam int NCH = VW / 64;

    typedef struct packed {
        logic [2:0]  sub;
        logic [1:0]  esz;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{3'b000, 2'b00, 64'h0102030405060708, 64'h1010101010101010, 64'h1112131415161718},
        '{3'b000, 2'b00, 64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, 64'h0000000000000000},
        '{3'b000, 2'b11, 64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, 64'h0101010101010100},
        '{3'b001, 2'b01, 64'h0000000580001234, 64'h0001000300010234, 64'hFFFF00027FFF1000},
        '{3'b100, 2'b00, 64'h7F807F800102F0F0, 64'h01FF80807EFEF020, 64'h7F80FF807F00E010},
        '{3'b101, 2'b00, 64'h7F807F800102F0F0, 64'h01FF80807EFEF020, 64'h80FFFFFF7FFFFFFF},
        '{3'b110, 2'b10, 64'h800000007FFFFFFF, 64'h00000001FFFFFFFF, 64'h800000007FFFFFFF},
        '{3'b111, 2'b01, 64'h00050003FFFF0000, 64'h0003000500010000, 64'h00020000FFFE0000},
        '{3'b110, 2'b11, 64'h8000000000000000, 64'h0000000000000001, 64'h8000000000000000},
        '{3'b100, 2'b11, 64'h7FFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h7FFFFFFFFFFFFFFF},
        '{3'b111, 2'b11, 64'h0000000000000001, 64'h0000000000000002, 64'h0000000000000000},
        '{3'b101, 2'b10, 64'hFFFFFFFE00000001, 64'h00000001FFFFFFFF, 64'hFFFFFFFFFFFFFFFF},
        '{3'b001, 2'b11, 64'h0000000000000000, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFFF},
        '{3'b100, 2'b01, 64'h80007FFF0001FFFF, 64'h80000001FFFFFFFF, 64'h80007FFF0000FFFE}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic          out_valid;
    logic          out_illegal;
    logic [4:0]    out_rd;
    logic [4:0]    out_rn;
    logic [4:0]    out_rm;
    logic [VW-1:0] out_result;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5ns clk = ~clk;

    vsat_unit #(.VEC_W(VW)) uut (
        .clk, .rst_n, .in_valid, .instr, .src_a, .src_b,
        .out_valid, .out_illegal, .out_rd, .out_rn, .out_rm, .out_result
    );

    function automatic logic [31:0] mk(logic [1:0] esz, logic [2:0] sub,
                                       logic [4:0] rd, logic [4:0] rn, logic [4:0] rm);
        return {8'b00000100, esz, 1'b1, rm, 3'b000, sub, rn, rd};
    endfunction

    function automatic logic [63:0] ref_lane(logic [2:0] sub, int w,
                                             logic [63:0] a_in, logic [63:0] b_in);
        logic [63:0] m, a, b;
        logic [64:0] s, d;
        logic signed [65:0] sa, sb, r, lo, hi;
        m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        a  = a_in & m;
        b  = b_in & m;
        s  = {1'b0, a} + {1'b0, b};
        d  = {1'b0, a} - {1'b0, b};
        sa = $signed({2'b00, a});
        sb = $signed({2'b00, b});
        if (a[w-1]) sa = sa - $signed(66'd1 << w);
        if (b[w-1]) sb = sb - $signed(66'd1 << w);
        hi = $signed(66'd1 << (w-1)) - 66'sd1;
        lo = -$signed(66'd1 << (w-1));
        case (sub)
            3'b000:  return s[63:0] & m;
            3'b001:  return d[63:0] & m;
            3'b101:  return (s > {1'b0, m}) ? m : s[63:0];
            3'b111:  return (a < b) ? 64'd0 : (a - b);
            3'b100, 3'b110: begin
                r = (sub == 3'b100) ? sa + sb : sa - sb;
                if (r > hi)      r = hi;
                else if (r < lo) r = lo;
                return r[63:0] & m;
            end
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic [VW-1:0] ref_vec(logic [2:0] sub, logic [1:0] esz,
                                              logic [VW-1:0] a, logic [VW-1:0] b);
        logic [VW-1:0] acc = '0;
        int w = 8 << esz;
        for (int k = 0; k < VW / w; k++) begin
            logic [63:0] l;
            l = ref_lane(sub, w, 64'(a >> (k*w)), 64'(b >> (k*w)));
            acc = acc | (VW'(l) << (k*w));
        end
        return acc;
    endfunction

    function automatic string tag_of(logic [2:0] sub);
        case (sub)
            3'b000:  return "R5";
            3'b001:  return "R6";
            3'b100:  return "R7";
            3'b101:  return "R8";
            3'b110:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic issue(logic [31:0] w, logic [VW-1:0] a, logic [VW-1:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = w;
        src_a    = a;
        src_b    = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk_illegal(string tag, logic [31:0] w);
        issue(w, {VW{1'b1}}, {VW{1'b1}});
        chk(tag, VW'({out_illegal, out_valid}), VW'(2'b10));
        chk("R12", VW'({out_rd, out_rn, out_rm}), '0);
        chk("R12", out_result, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] a, b;
        logic [31:0]   w;
        logic [2:0]    subs [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};

        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11", VW'({out_valid, out_illegal, out_rd, out_rn, out_rm}), '0);
        chk("R11", out_result, '0);
        rst_n = 1'b1;

        // table of hand-worked vectors, replicated across the vector
        for (int i = 0; i < NVEC; i++) begin
            w = mk(VECS[i].esz, VECS[i].sub, 5'(i), 5'(i + 7), 5'(31 - i));
            issue(w, {NCH{VECS[i].a}}, {NCH{VECS[i].b}});
            chk(tag_of(VECS[i].sub), out_result, {NCH{VECS[i].exp}});
            chk("R3", VW'({out_valid, out_rd, out_rn, out_rm}),
                VW'({1'b1, 5'(i), 5'(i + 7), 5'(31 - i)}));
        end

        // R11: the flag lasts one cycle only
        @(negedge clk);
        chk("R11", VW'({out_valid, out_illegal}), '0);

        // random and saturated-pattern operands, every op and size (R4)
        for (int si = 0; si < 6; si++) begin
            for (int e = 0; e < 4; e++) begin
                for (int rep = 0; rep < 6; rep++) begin
                    a = {$urandom, $urandom, $urandom, $urandom};
                    b = {$urandom, $urandom, $urandom, $urandom};
                    if (rep == 0) a = {VW{1'b1}};
                    if (rep == 1) b = {NCH*8{8'h80}};
                    if (rep == 2) begin a = {NCH*8{8'h7F}}; b = {NCH*8{8'h7F}}; end
                    w = mk(2'(e), subs[si], 5'(rep), 5'(e), 5'(si));
                    issue(w, a, b);
                    chk(e == 0 ? "R4" : tag_of(subs[si]), out_result,
                        ref_vec(subs[si], 2'(e), a, b));
                end
            end
        end

        // R1: group match bits
        chk_illegal("R1", mk(2'b00, 3'b000, 5'd1, 5'd2, 5'd3) ^ 32'h0100_0000);
        chk_illegal("R1", mk(2'b10, 3'b101, 5'd1, 5'd2, 5'd3) & ~32'h0020_0000);
        chk_illegal("R1", mk(2'b01, 3'b100, 5'd1, 5'd2, 5'd3) | 32'h0000_2000);
        // R2: sub-opcodes 010 and 011
        chk_illegal("R2", mk(2'b00, 3'b010, 5'd4, 5'd5, 5'd6));
        chk_illegal("R2", mk(2'b11, 3'b011, 5'd4, 5'd5, 5'd6));

        // R11: reset during a live result clears outputs
        issue(mk(2'b00, 3'b000, 5'd9, 5'd9, 5'd9), {VW{1'b1}}, {VW{1'b1}});
        rst_n = 1'b0;
        #1ns;
        chk("R11", VW'({out_valid, out_illegal, out_rd}), '0);
        chk("R11", out_result, '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule